// File: doc/BRIEF.md
# Per-Channel DMA Descriptor Queue

This block sits between a register write port and sixteen transfer engines. Software builds a transfer descriptor one word at a time, staging a source address, a destination address and a size word. It then writes a channel number, which commits the staged descriptor to that channel's private queue. Each enabled channel offers the oldest descriptor in its queue on its own pop port. The channel's engine takes it with a ready/valid handshake.

Each channel reports its pending count, a full flag, a single-cycle overflow pulse and a single-cycle low-watermark pulse. The block also keeps the channel enable bitmap. It reports that bitmap together with the lowest-numbered channel that is not enabled, so software can find a free channel in one read.

Switching a channel off is not immediate. The enable stays visible until the engine stops being busy. A descriptor can also turn its channel off on its own once the engine signals completion.

Top module: `dq_desc_queue`

## Requirements
- R1: `wr_sel` selects the target of a write. Value 0 stages the source address, 1 stages the destination address and 2 stages the size word. Value 3 commits {source, destination, size} to the queue of channel `wr_data`; a value of 16 or more is discarded. Staged words are kept after a commit and can be reused.
- R2: Each channel's queue is first-in first-out. The pop port shows the oldest descriptor, and a cycle with `pop_valid` and `pop_ready` both high removes it.
- R3: A commit to a full queue is dropped, and `ovf_evt` for that channel is high for exactly the next cycle.
- R4: `pend_cnt` (6 bits) holds the number of queued descriptors and `q_full` is high when that number equals the depth. Both reflect a push or pop in the cycle after its clock edge. A push and a pop in the same cycle leave the count unchanged.
- R5: `lwm_evt` for a channel is high for one cycle when a pop with no accepted push lowers that channel's count from `lwm_level`+1 to `lwm_level`.
- R6: `pop_valid` is high only when the channel is enabled, no stop is pending and the queue is not empty.
- R7: `nf_word` bits 4:0 give the lowest channel that is not enabled, or 16 when all channels are enabled. Bits 31:16 give the enable bitmap, with channel n at bit 16+n. Bits 15:5 are zero.
- R8: An `en_wr` cycle sets each channel whose `en_wdata` bit is 1, which also cancels any pending stop. A 0 bit on an enabled channel requests a stop. A channel with a pending stop clears its enable in the first clock edge at which `eng_busy` is low; until then its enable still reads 1.
- R9: If bit 24 of the size word of the last descriptor popped on a channel is set, an `eng_done` pulse on that channel clears its enable at that edge.
- R10: After reset all queues are empty, no channel is enabled, no event is high and `nf_word` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 source, 1 destination, 2 size, 3 channel/commit |
| wr_data | input | 32 | Register write data |
| en_wr | input | 1 | Enable-bitmap write strobe |
| en_wdata | input | 16 | New enable bitmap |
| lwm_level | input | 16x4 | Low-watermark level per channel |
| pop_ready | input | 16 | Engine takes the head descriptor |
| eng_busy | input | 16 | Engine is mid-transfer |
| eng_done | input | 16 | Engine finished a descriptor |
| pop_valid | output | 16 | Head descriptor available |
| pop_src | output | 16x32 | Head source address |
| pop_dst | output | 16x32 | Head destination address |
| pop_size | output | 16x32 | Head size word |
| pend_cnt | output | 16x6 | Pending descriptor count |
| q_full | output | 16 | Queue full |
| lwm_evt | output | 16 | Low-watermark pulse |
| ovf_evt | output | 16 | Overflow pulse |
| nf_word | output | 32 | Free channel and enable bitmap |

## Verification
Every result here is due one cycle after the clock edge that takes the stimulus. Counts, full flags, pop heads, events and the free-channel word all come from registers, and none of them depends combinationally on an input. The bench drives inputs on the falling edge and advances its queue model on the rising edge. It compares every output on the next falling edge, so each check lands exactly one edge after its cause. Delayed stops and auto-disable are timed against the `eng_busy` and `eng_done` edges by the same one-edge rule.

// File: rtl/dq_pkg.sv
package dq_pkg;
    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] size;
    } desc_t;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_SIZE = 2'd2,
        SEL_CHAN = 2'd3
    } wsel_e;

    localparam int unsigned AUTO_OFF_BIT = 24;
endpackage

// File: rtl/dq_stager.sv
module dq_stager
    import dq_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [31:0]     wr_data,
    output logic            commit,
    output logic [CHW-1:0]  commit_ch,
    output desc_t           desc
);
    typedef struct packed {
        desc_t stage;
    } stg_t;

    stg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_SRC:  st_d.stage.src  = wr_data;
                SEL_DST:  st_d.stage.dst  = wr_data;
                SEL_SIZE: st_d.stage.size = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit    = wr_en && (wr_sel == SEL_CHAN) && (wr_data < 32'(NCH));
    assign commit_ch = wr_data[CHW-1:0];
    assign desc      = st_q.stage;
endmodule

// File: rtl/dq_fifo.sv
module dq_fifo
    import dq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  desc_t          wdata,
    output desc_t          rdata,
    output logic [CW-1:0]  count,
    output logic           full,
    output logic           empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t  p_d, p_q;
    desc_t mem_q [DEPTH];
    logic  do_push, do_pop;

    assign full    = (p_q.cnt == CW'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wr = (p_q.wr == AW'(DEPTH - 1)) ? '0 : p_q.wr + 1'b1;
        if (do_pop)  p_d.rd = (p_q.rd == AW'(DEPTH - 1)) ? '0 : p_q.rd + 1'b1;
        p_d.cnt = p_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= wdata;
    end

    assign rdata = mem_q[p_q.rd];
    assign count = p_q.cnt;
endmodule

// File: rtl/dq_free_enc.sv
module dq_free_enc #(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] en,
    output logic [4:0]     free_idx
);
    always_comb begin
        free_idx = 5'(NCH);
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!en[i]) free_idx = 5'(i);
        end
    end
endmodule

// File: rtl/dq_desc_queue.sv
module dq_desc_queue
    import dq_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int DEPTH = 16,
    localparam int CHW  = $clog2(NCH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [31:0]               wr_data,
    input  logic                      en_wr,
    input  logic [NCH-1:0]            en_wdata,
    input  logic [NCH-1:0][3:0]       lwm_level,
    input  logic [NCH-1:0]            pop_ready,
    input  logic [NCH-1:0]            eng_busy,
    input  logic [NCH-1:0]            eng_done,
    output logic [NCH-1:0]            pop_valid,
    output logic [NCH-1:0][31:0]      pop_src,
    output logic [NCH-1:0][31:0]      pop_dst,
    output logic [NCH-1:0][31:0]      pop_size,
    output logic [NCH-1:0][5:0]       pend_cnt,
    output logic [NCH-1:0]            q_full,
    output logic [NCH-1:0]            lwm_evt,
    output logic [NCH-1:0]            ovf_evt,
    output logic [31:0]               nf_word
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] stop;
        logic [NCH-1:0] af;
        logic [NCH-1:0] lwm_evt;
        logic [NCH-1:0] ovf_evt;
    } ctl_t;

    ctl_t           st_d, st_q;
    logic           commit;
    logic [CHW-1:0] commit_ch;
    desc_t          stage_desc;
    desc_t          head [NCH];
    logic [NCH-1:0] empty_w, push_req, push_ok, pop_fire;
    logic [4:0]     free_idx;

    dq_stager #(.NCH(NCH)) u_stager (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .commit(commit), .commit_ch(commit_ch),
        .desc(stage_desc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CW-1:0] cnt_w;
        assign push_req[c] = commit && (commit_ch == CHW'(c));
        assign push_ok[c]  = push_req[c] && !q_full[c];
        assign pop_fire[c] = pop_valid[c] && pop_ready[c];
        assign pop_valid[c] = st_q.en[c] && !st_q.stop[c] && !empty_w[c];

        dq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_req[c]), .pop(pop_fire[c]),
            .wdata(stage_desc), .rdata(head[c]), .count(cnt_w),
            .full(q_full[c]), .empty(empty_w[c])
        );

        assign pend_cnt[c] = 6'(cnt_w);
        assign pop_src[c]  = head[c].src;
        assign pop_dst[c]  = head[c].dst;
        assign pop_size[c] = head[c].size;
    end

    always_comb begin
        st_d = st_q;
        st_d.lwm_evt = '0;
        st_d.ovf_evt = '0;
        for (int c = 0; c < NCH; c++) begin
            if (push_req[c] && q_full[c]) st_d.ovf_evt[c] = 1'b1;
            if (pop_fire[c] && !push_ok[c] &&
                (pend_cnt[c] == 6'(lwm_level[c]) + 6'd1))
                st_d.lwm_evt[c] = 1'b1;
            if (eng_done[c]) st_d.af[c] = 1'b0;
            if (pop_fire[c]) st_d.af[c] = pop_size[c][AUTO_OFF_BIT];
            if (st_q.stop[c] && !eng_busy[c]) begin
                st_d.en[c]   = 1'b0;
                st_d.stop[c] = 1'b0;
            end
            if (eng_done[c] && st_q.af[c]) begin
                st_d.en[c]   = 1'b0;
                st_d.stop[c] = 1'b0;
            end
            if (en_wr) begin
                if (en_wdata[c]) begin
                    st_d.en[c]   = 1'b1;
                    st_d.stop[c] = 1'b0;
                end else begin
                    st_d.stop[c] = st_d.en[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dq_free_enc #(.NCH(NCH)) u_free (.en(st_q.en), .free_idx(free_idx));

    assign lwm_evt = st_q.lwm_evt;
    assign ovf_evt = st_q.ovf_evt;
    assign nf_word = {16'(st_q.en), 11'd0, free_idx};
endmodule

// File: rtl/dq_desc_queue_chk.sv
module dq_desc_queue_chk #(
    parameter int NCH   = 16,
    parameter int DEPTH = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_wr,
    input logic [NCH-1:0][3:0]  lwm_level,
    input logic [NCH-1:0]       eng_busy,
    input logic [NCH-1:0]       eng_done,
    input logic [NCH-1:0]       pop_valid,
    input logic [NCH-1:0][5:0]  pend_cnt,
    input logic [NCH-1:0]       q_full,
    input logic [NCH-1:0]       lwm_evt,
    input logic [NCH-1:0]       ovf_evt,
    input logic [31:0]          nf_word
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        a_r6_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            pop_valid[c] |-> nf_word[16+c]);
        a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (7'(pend_cnt[c]) <= 7'($past(pend_cnt[c])) + 7'd1) &&
            (7'(pend_cnt[c]) + 7'd1 >= 7'($past(pend_cnt[c]))));
        a_r4_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
            q_full[c] |-> (pend_cnt[c] == 6'(DEPTH)));
        a_r3_overflow_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_evt[c] |-> $past(q_full[c]));
        a_r5_lwm_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
            lwm_evt[c] |-> (7'(pend_cnt[c]) + 7'd1 == 7'($past(pend_cnt[c]))) &&
                           (pend_cnt[c] == 6'(lwm_level[c])));
        a_r8_stop_waits_busy: assert property (@(posedge clk) disable iff (!rst_n)
            $past(nf_word[16+c] && eng_busy[c] && !en_wr && !eng_done[c]) |-> nf_word[16+c]);
        a_r7_free_is_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            (nf_word[4:0] == 5'(c)) |-> !nf_word[16+c]);
    end
    a_r7_all_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_word[4:0] == 5'(NCH)) |-> (&nf_word[16 +: NCH]));
endmodule

bind dq_desc_queue dq_desc_queue_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_dq_desc_queue.sv
module sim_dq_desc_queue;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic en_wr = 1'b0;
    logic [NCH-1:0] en_wdata = '0;
    logic [NCH-1:0][3:0] lwm_level = '0;
    logic [NCH-1:0] pop_ready = '0, eng_busy = '0, eng_done = '0;
    logic [NCH-1:0] pop_valid, q_full, lwm_evt, ovf_evt;
    logic [NCH-1:0][31:0] pop_src, pop_dst, pop_size;
    logic [NCH-1:0][5:0] pend_cnt;
    logic [31:0] nf_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    dq_desc_queue #(.NCH(NCH), .DEPTH(DEPTH)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [95:0] mq [NCH][$];
    logic [31:0] m_src, m_dst, m_size;
    logic [NCH-1:0] m_en, m_stop, m_af, m_lwm, m_ovf;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) mq[c].delete();
            m_src = 0; m_dst = 0; m_size = 0;
            m_en = 0; m_stop = 0; m_af = 0; m_lwm = 0; m_ovf = 0;
        end else begin
            logic [NCH-1:0] en_o, stop_o, af_o;
            bit pc;
            int ch;
            en_o = m_en; stop_o = m_stop; af_o = m_af;
            m_lwm = 0; m_ovf = 0;
            pc = wr_en && wr_sel == 2'd3 && wr_data < NCH;
            ch = int'(wr_data[3:0]);
            for (int c = 0; c < NCH; c++) begin
                bit pf, pushed;
                int old;
                old = mq[c].size();
                pf = en_o[c] && !stop_o[c] && old > 0 && pop_ready[c];
                pushed = pc && ch == c && old < DEPTH;
                if (pc && ch == c && old == DEPTH) m_ovf[c] = 1'b1;
                if (eng_done[c]) m_af[c] = 1'b0;
                if (pf) begin
                    m_af[c] = mq[c][0][24];
                    void'(mq[c].pop_front());
                end
                if (pushed) mq[c].push_back({m_src, m_dst, m_size});
                if (pf && !pushed && old == int'(lwm_level[c]) + 1) m_lwm[c] = 1'b1;
                if (stop_o[c] && !eng_busy[c]) begin m_en[c] = 0; m_stop[c] = 0; end
                if (eng_done[c] && af_o[c]) begin m_en[c] = 0; m_stop[c] = 0; end
                if (en_wr) begin
                    if (en_wdata[c]) begin m_en[c] = 1; m_stop[c] = 0; end
                    else m_stop[c] = m_en[c];
                end
            end
            if (wr_en && wr_sel == 2'd0) m_src = wr_data;
            if (wr_en && wr_sel == 2'd1) m_dst = wr_data;
            if (wr_en && wr_sel == 2'd2) m_size = wr_data;
        end
    end

    function automatic logic [31:0] exp_nf();
        logic [4:0] f;
        f = 5'(NCH);
        for (int i = NCH - 1; i >= 0; i--) if (!m_en[i]) f = 5'(i);
        return {16'(m_en), 11'd0, f};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            logic [NCH*6-1:0] ecnt;
            logic [NCH-1:0] efull, evalid;
            for (int c = 0; c < NCH; c++) begin
                ecnt[c*6 +: 6] = 6'(mq[c].size());
                efull[c] = (mq[c].size() == DEPTH);
                evalid[c] = m_en[c] && !m_stop[c] && mq[c].size() > 0;
            end
            chk(pend_cnt == ecnt, "R4 count", 128'(pend_cnt), 128'(ecnt));
            chk(q_full == efull, "R4 full", 128'(q_full), 128'(efull));
            chk(pop_valid == evalid, "R6 valid", 128'(pop_valid), 128'(evalid));
            chk(ovf_evt == m_ovf, "R3 overflow", 128'(ovf_evt), 128'(m_ovf));
            chk(lwm_evt == m_lwm, "R5 watermark", 128'(lwm_evt), 128'(m_lwm));
            chk(nf_word == exp_nf(), "R7 R8 R9 nextfree", 128'(nf_word), 128'(exp_nf()));
            for (int c = 0; c < NCH; c++) begin
                if (evalid[c] && pop_valid[c])
                    chk({pop_src[c], pop_dst[c], pop_size[c]} == mq[c][0], "R1 R2 head",
                        128'({pop_src[c], pop_dst[c], pop_size[c]}), 128'(mq[c][0]));
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_en(input logic [NCH-1:0] m);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = m;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic put(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] z);
        wr(2'd0, s); wr(2'd1, d); wr(2'd2, z); wr(2'd3, 32'(ch));
    endtask

    task automatic summary();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int c = 0; c < NCH; c++) lwm_level[c] = 4'(c % 7 + 2);
        lwm_level[3] = 4'd13;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(nf_word == 32'h0 && pend_cnt == '0 && pop_valid == '0 && ovf_evt == '0,
            "R10 reset", 128'(nf_word), 0);
        set_en(16'h0027);
        @(negedge clk);
        chk(nf_word[4:0] == 5'd3, "R7 lowest free", 128'(nf_word[4:0]), 3);
        for (int i = 0; i < 18; i++) put(3, 32'h1000 + i, 32'h2000 + i, 32'h40 + i);
        chk(pend_cnt[3] == 6'd16, "R3 kept depth", 128'(pend_cnt[3]), 16);
        wr(2'd3, 32'd20);
        @(negedge clk);
        chk(pend_cnt[3] == 6'd16 && pend_cnt[4] == 6'd0, "R1 bad channel ignored",
            128'(pend_cnt[3]), 16);
        set_en(16'h002F);
        @(negedge clk);
        chk(pop_src[3] == 32'h1000, "R2 oldest first", 128'(pop_src[3]), 32'h1000);
        pop_ready[3] = 1'b1;
        repeat (5) @(negedge clk);
        pop_ready[3] = 1'b0;
        chk(pend_cnt[3] == 6'd11, "R4 after pops", 128'(pend_cnt[3]), 11);
        // R8 delayed stop
        eng_busy[3] = 1'b1;
        set_en(16'h0027);
        repeat (3) @(negedge clk);
        chk(nf_word[19] == 1'b1 && pop_valid[3] == 1'b0, "R8 held while busy", 128'(nf_word[19]), 1);
        eng_busy[3] = 1'b0;
        @(negedge clk);
        chk(nf_word[19] == 1'b0, "R8 stopped", 128'(nf_word[19]), 0);
        // R9 auto-disable
        set_en(16'h00A7);
        put(7, 32'hA0, 32'hB0, 32'h0100_0020);
        pop_ready[7] = 1'b1;
        repeat (2) @(negedge clk);
        pop_ready[7] = 1'b0;
        chk(nf_word[23] == 1'b1, "R9 enabled before done", 128'(nf_word[23]), 1);
        eng_done[7] = 1'b1;
        @(negedge clk);
        eng_done[7] = 1'b0;
        chk(nf_word[23] == 1'b0, "R9 auto off", 128'(nf_word[23]), 0);
        set_en('1);
        @(negedge clk);
        chk(nf_word[4:0] == 5'd16, "R7 all enabled", 128'(nf_word[4:0]), 16);
        // mixed traffic
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            wr_en = ($urandom % 3) != 0;
            wr_sel = 2'($urandom);
            wr_data = (wr_sel == 2'd3) ? 32'($urandom % 18) : $urandom;
            pop_ready = 16'($urandom) & 16'($urandom);
            eng_busy = 16'($urandom);
            eng_done = 16'($urandom) & 16'($urandom) & 16'($urandom);
            en_wr = ($urandom % 40) == 0;
            en_wdata = 16'($urandom) | 16'($urandom);
        end
        @(negedge clk);
        wr_en = 0; en_wr = 0; pop_ready = 0; eng_busy = 0; eng_done = 0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule